// File: doc/BRIEF.md
# Line Phase Detector Gating Controller

This block sets how strongly the horizontal phase detector pushes the line loop, and when it is allowed to look at incoming sync at all. It takes a noise flag, a lock flag from the coincidence check and a vertical-retrace flag. From these it produces a charge-pump current code, a gate window placed symmetrically around the expected sync position, and a fast/slow select for the loop time constant. The charge pump, the loop filter and the noise detector are outside the block.

A one-cycle line strobe from the line timebase marks the start of each line. Every flag is sampled on that strobe only, so a mode never changes part-way through a line. A position counter restarts on the strobe. The expected sync centre lies `SYNC_OFS` clocks after it, and the gate window is laid around that point.

The noise flag first passes a two-line confirmation filter. Its states are NZ_CLEAN, NZ_CLEAN_DOUBT, NZ_NOISY and NZ_NOISY_DOUBT:
- On a strobe with the flag set, NZ_CLEAN moves to NZ_CLEAN_DOUBT, and NZ_CLEAN_DOUBT moves to NZ_NOISY.
- On a strobe with the flag clear, NZ_NOISY moves to NZ_NOISY_DOUBT, and NZ_NOISY_DOUBT moves to NZ_CLEAN.
- The opposite flag value sends a DOUBT state back to the state it came from.

The loop-mode machine then picks one of three states on every strobe:
- LM_FREE when not locked.
- LM_STRONG when locked and the confirmed noise is clear.
- LM_WEAK when locked and the confirmed noise is set.

Both machines use the filter result produced by that same strobe.

Top module: `line_pd_gate_ctrl`

## Requirements
- R1: After reset and before the first strobe, `pd_current` is 180, `pd_enable` is 1, `gate_window` is 0 and `loop_slow` is 0.
- R2: `loop_slow` is 1 exactly when the confirmed noise state is set. That state becomes set only after the noise flag is seen high on two consecutive strobes, and clears only after the flag is seen low on two consecutive strobes. A single-line blip leaves it unchanged. The new value appears in the cycle after the confirming strobe.
- R3: When the lock flag sampled at the strobe is low, the current code is 180 during scan and 270 during retrace. In that mode `pd_enable` stays 1 and `gate_window` stays 0 for the whole line, whatever the noise state.
- R4: Locked with confirmed noise clear, the current code is 180 during scan and 270 during retrace.
- R5: Locked with confirmed noise set, the current code is 30 during both scan and retrace.
- R6: Locked, confirmed noise clear, with the retrace flag set at the strobe, gating is active with the wide window. The width is WIDE = round(CLK_MHZ*12) clocks. The window covers counter positions SYNC_OFS-WIDE/2 to SYNC_OFS-WIDE/2+WIDE-1, where position 0 is the cycle right after the strobe edge. In this mode `gate_window` is 1 and `pd_enable` is 1 inside the window, and both are 0 outside it.
- R7: Locked, confirmed noise clear, with the retrace flag clear at the strobe, the detector is not gated: `pd_enable` is 1 and `gate_window` is 0 all line.
- R8: Locked with confirmed noise set, gating is active in both scan and retrace lines with the narrow window. The width is NARROW = round(CLK_MHZ*5.7) clocks, placed from SYNC_OFS-NARROW/2 in the same way as R6.
- R9: Changes on the noise, lock and retrace inputs between strobes have no effect on any output until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| noise_det | input | 1 | Raw noise-detected flag |
| pll_locked | input | 1 | Line loop lock flag from the coincidence check |
| vretrace | input | 1 | Vertical retrace in progress |
| sync_strobe | input | 1 | One-cycle line start strobe from the line timebase |
| pd_current | output | 9 | Phase-detector current code (30, 180 or 270) |
| pd_enable | output | 1 | Phase detector may act on sync this cycle |
| gate_window | output | 1 | Gating is active and the window is open |
| loop_slow | output | 1 | 1 selects the slow loop time constant |

## Verification
Some properties are checked on every cycle:
- The current code is always one of the three legal values.
- The code and the speed select move only in the cycle after a strobe.
- A weak-signal code implies slow mode.
- A scan-rate code of 180 never coincides with gating.
- Every closed window lasts exactly the wide or the narrow width.

Other behaviour only the bench scenarios can show:
- The exact window position relative to the strobe.
- The two-line noise confirmation, including single-line blips and asymmetric runs.
- The mapping from each lock, noise and retrace combination to code and gating.
- Insensitivity to input toggles between strobes.

// File: rtl/pd_gate_pkg.sv
package pd_gate_pkg;

    localparam int unsigned CUR_W       = 9;
    localparam int unsigned CUR_WEAK    = 30;
    localparam int unsigned CUR_SCAN    = 180;
    localparam int unsigned CUR_RETRACE = 270;

    typedef enum logic [1:0] {
        NZ_CLEAN       = 2'd0,
        NZ_CLEAN_DOUBT = 2'd1,
        NZ_NOISY       = 2'd2,
        NZ_NOISY_DOUBT = 2'd3
    } nz_state_t;

    typedef enum logic [1:0] {
        LM_FREE   = 2'd0,
        LM_STRONG = 2'd1,
        LM_WEAK   = 2'd2
    } loop_mode_t;

endpackage

// File: rtl/pd_noise_confirm.sv
module pd_noise_confirm
    import pd_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic noise_raw,
    output logic noisy_q,
    output logic noisy_next
);

    nz_state_t nz_q;
    nz_state_t nz_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nz_q <= NZ_CLEAN;
        end else begin
            nz_q <= nz_d;
        end
    end

    always_comb begin
        nz_d = nz_q;
        if (line_tick) begin
            unique case (nz_q)
                NZ_CLEAN:       nz_d = noise_raw ? NZ_CLEAN_DOUBT : NZ_CLEAN;
                NZ_CLEAN_DOUBT: nz_d = noise_raw ? NZ_NOISY       : NZ_CLEAN;
                NZ_NOISY:       nz_d = noise_raw ? NZ_NOISY       : NZ_NOISY_DOUBT;
                NZ_NOISY_DOUBT: nz_d = noise_raw ? NZ_NOISY       : NZ_CLEAN;
                default:        nz_d = NZ_CLEAN;
            endcase
        end
    end

    assign noisy_q    = (nz_q == NZ_NOISY) || (nz_q == NZ_NOISY_DOUBT);
    assign noisy_next = (nz_d == NZ_NOISY) || (nz_d == NZ_NOISY_DOUBT);

endmodule

// File: rtl/pd_loop_mode.sv
module pd_loop_mode
    import pd_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic             locked_raw,
    input  logic             retrace_raw,
    input  logic             noisy_next,
    output logic [CUR_W-1:0] cur_code,
    output logic             gate_req,
    output logic             narrow_sel
);

    loop_mode_t mode_q;
    loop_mode_t mode_d;
    logic       retrace_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= LM_FREE;
            retrace_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (line_tick) begin
                retrace_q <= retrace_raw;
            end
        end
    end

    always_comb begin
        mode_d = mode_q;
        if (line_tick) begin
            unique case ({locked_raw, noisy_next})
                2'b00, 2'b01: mode_d = LM_FREE;
                2'b10:        mode_d = LM_STRONG;
                2'b11:        mode_d = LM_WEAK;
                default:      mode_d = LM_FREE;
            endcase
        end
    end

    always_comb begin
        cur_code   = retrace_q ? CUR_W'(CUR_RETRACE) : CUR_W'(CUR_SCAN);
        gate_req   = 1'b0;
        narrow_sel = 1'b0;
        unique case (mode_q)
            LM_FREE: begin
                gate_req = 1'b0;
            end
            LM_STRONG: begin
                gate_req = retrace_q;
            end
            LM_WEAK: begin
                cur_code   = CUR_W'(CUR_WEAK);
                gate_req   = 1'b1;
                narrow_sel = 1'b1;
            end
            default: begin
                gate_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pd_gate_window.sv
module pd_gate_window #(
    parameter int unsigned WIDE_CYC   = 1500,
    parameter int unsigned NARROW_CYC = 713,
    parameter int unsigned SYNC_OFS   = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic narrow_sel,
    output logic in_window
);

    localparam int unsigned POS_W = $clog2(SYNC_OFS + WIDE_CYC + 2);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    logic [POS_W-1:0] pos_q;
    logic [1:0]       hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= POS_MAX;
        end else if (line_tick) begin
            pos_q <= '0;
        end else if (pos_q != POS_MAX) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // index 0: wide window, index 1: narrow window
    for (genvar g = 0; g < 2; g++) begin : g_win
        localparam int unsigned W_CYC = (g == 0) ? WIDE_CYC : NARROW_CYC;
        localparam logic [POS_W-1:0] W_OPEN = POS_W'(SYNC_OFS - W_CYC / 2);
        localparam logic [POS_W-1:0] W_LAST = POS_W'(SYNC_OFS - W_CYC / 2 + W_CYC - 1);
        assign hit[g] = (pos_q >= W_OPEN) && (pos_q <= W_LAST);
    end

    assign in_window = narrow_sel ? hit[1] : hit[0];

endmodule

// File: rtl/line_pd_gate_ctrl.sv
module line_pd_gate_ctrl
    import pd_gate_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 125,
    parameter int unsigned SYNC_OFS = 800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             noise_det,
    input  logic             pll_locked,
    input  logic             vretrace,
    input  logic             sync_strobe,
    output logic [CUR_W-1:0] pd_current,
    output logic             pd_enable,
    output logic             gate_window,
    output logic             loop_slow
);

    localparam int unsigned WIDE_CYC   = (CLK_MHZ * 120 + 5) / 10;
    localparam int unsigned NARROW_CYC = (CLK_MHZ * 57 + 5) / 10;

    logic noisy_q;
    logic noisy_next;
    logic gate_req;
    logic narrow_sel;
    logic in_window;

    pd_noise_confirm u_noise (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (sync_strobe),
        .noise_raw  (noise_det),
        .noisy_q    (noisy_q),
        .noisy_next (noisy_next)
    );

    pd_loop_mode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_tick   (sync_strobe),
        .locked_raw  (pll_locked),
        .retrace_raw (vretrace),
        .noisy_next  (noisy_next),
        .cur_code    (pd_current),
        .gate_req    (gate_req),
        .narrow_sel  (narrow_sel)
    );

    pd_gate_window #(
        .WIDE_CYC   (WIDE_CYC),
        .NARROW_CYC (NARROW_CYC),
        .SYNC_OFS   (SYNC_OFS)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (sync_strobe),
        .narrow_sel (narrow_sel),
        .in_window  (in_window)
    );

    assign pd_enable   = !gate_req || in_window;
    assign gate_window = gate_req && in_window;
    assign loop_slow   = noisy_q;

endmodule

// File: rtl/pd_gate_checker.sv
module pd_gate_checker #(
    parameter int unsigned CLK_MHZ = 125
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_strobe,
    input logic [8:0] pd_current,
    input logic       pd_enable,
    input logic       gate_window,
    input logic       loop_slow
);

    localparam int unsigned WIDE_CYC   = (CLK_MHZ * 120 + 5) / 10;
    localparam int unsigned NARROW_CYC = (CLK_MHZ * 57 + 5) / 10;

    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (gate_window) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_current == 9'd30) || (pd_current == 9'd180) || (pd_current == 9'd270)); // R3

    AST_CODE_HOLDS_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sync_strobe) |-> $stable(pd_current)); // R9

    AST_SPEED_HOLDS_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sync_strobe) |-> $stable(loop_slow)); // R2

    AST_WEAK_IS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_current == 9'd30) |-> loop_slow); // R5

    AST_SCAN_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_current == 9'd180) |-> (pd_enable && !gate_window)); // R7

    AST_WINDOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_window) && !$past(sync_strobe)) |->
        ((run_q == 16'(WIDE_CYC)) || (run_q == 16'(NARROW_CYC)))); // R6

endmodule

bind line_pd_gate_ctrl pd_gate_checker #(.CLK_MHZ(CLK_MHZ)) u_pd_gate_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_strobe (sync_strobe),
    .pd_current  (pd_current),
    .pd_enable   (pd_enable),
    .gate_window (gate_window),
    .loop_slow   (loop_slow)
);

// File: tb/line_pd_gate_ctrl_test.sv
module line_pd_gate_ctrl_test;

    localparam int unsigned CLK_MHZ  = 20;
    localparam int unsigned SYNC_OFS = 160;
    localparam int unsigned LINE     = 400;
    localparam int unsigned WIDE     = 240;   // round(20*12)
    localparam int unsigned NARROW   = 114;   // round(20*5.7)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       noise_det = 1'b0;
    logic       pll_locked = 1'b0;
    logic       vretrace = 1'b0;
    logic       sync_strobe = 1'b0;
    logic [8:0] pd_current;
    logic       pd_enable;
    logic       gate_window;
    logic       loop_slow;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // bench model of the flags captured at the last strobe
    bit m_prev = 1'b0;
    bit m_conf = 1'b0;
    bit m_lock = 1'b0;
    bit m_vr   = 1'b0;

    always #4 clk = ~clk;

    line_pd_gate_ctrl #(.CLK_MHZ(CLK_MHZ), .SYNC_OFS(SYNC_OFS)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .noise_det   (noise_det),
        .pll_locked  (pll_locked),
        .vretrace    (vretrace),
        .sync_strobe (sync_strobe),
        .pd_current  (pd_current),
        .pd_enable   (pd_enable),
        .gate_window (gate_window),
        .loop_slow   (loop_slow)
    );

    function automatic int exp_code();
        if (m_lock && m_conf) return 30;
        return m_vr ? 270 : 180;
    endfunction

    function automatic bit exp_gated();
        return m_lock && (m_conf || m_vr);
    endfunction

    function automatic bit exp_inwin(int pos);
        int w;
        int op;
        w  = m_conf ? NARROW : WIDE;
        op = SYNC_OFS - w / 2;
        return (pos >= op) && (pos < op + w);
    endfunction

    function automatic string mode_tag();
        if (!m_lock) return "R3";
        if (m_conf) return "R8";
        return m_vr ? "R6" : "R7";
    endfunction

    function automatic string code_tag();
        if (!m_lock) return "R3";
        return m_conf ? "R5" : "R4";
    endfunction

    task automatic chk(string ctx, string req, string what, int pos, int got, int expv);
        n_chk++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s %s %s pos=%0d actual=%0d expected=%0d", req, ctx, what, pos, got, expv);
        end
    endtask

    task automatic check_cycle(string ctx, int pos);
        bit g;
        bit iw;
        g  = exp_gated();
        iw = exp_inwin(pos);
        chk(ctx, code_tag(), "pd_current", pos, int'(pd_current), exp_code());
        chk(ctx, mode_tag(), "pd_enable", pos, int'(pd_enable), int'(!g || iw));
        chk(ctx, mode_tag(), "gate_window", pos, int'(gate_window), int'(g && iw));
        chk(ctx, "R2", "loop_slow", pos, int'(loop_slow), int'(m_conf));
    endtask

    // called at a negative edge; returns at the negative edge before the next strobe
    task automatic run_line(bit nz, bit lk, bit vr, bit scramble, string ctx);
        noise_det   = nz;
        pll_locked  = lk;
        vretrace    = vr;
        sync_strobe = 1'b1;
        if (nz == m_prev && nz != m_conf) m_conf = nz;
        m_prev = nz;
        m_lock = lk;
        m_vr   = vr;
        @(negedge clk);
        sync_strobe = 1'b0;
        for (int j = 0; j < int'(LINE) - 1; j++) begin
            check_cycle(ctx, j);
            if (scramble && $urandom_range(0, 7) == 0) begin
                noise_det  = 1'($urandom_range(0, 1));
                pll_locked = 1'($urandom_range(0, 1));
                vretrace   = 1'($urandom_range(0, 1));
            end
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit nz;
        bit lk;
        bit vr;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values before any strobe
        for (int k = 0; k < 12; k++) begin
            chk("reset", "R1", "pd_current", k, int'(pd_current), 180);
            chk("reset", "R1", "pd_enable", k, int'(pd_enable), 1);
            chk("reset", "R1", "gate_window", k, int'(gate_window), 0);
            chk("reset", "R1", "loop_slow", k, int'(loop_slow), 0);
            @(negedge clk);
        end

        run_line(0, 1, 0, 0, "strong scan R4 R7");
        run_line(0, 1, 1, 0, "strong retrace R4 R6");
        run_line(1, 1, 0, 0, "single noisy line R2");
        run_line(0, 1, 0, 0, "blip ignored R2");
        run_line(1, 1, 0, 0, "noise first line R2");
        run_line(1, 1, 0, 0, "noise confirmed R2 R5 R8");
        run_line(1, 1, 1, 0, "weak retrace R5 R8");
        run_line(0, 1, 1, 0, "one clean line still weak R2");
        run_line(1, 1, 0, 0, "clean blip ignored R2");
        run_line(0, 1, 0, 0, "clean first line R2");
        run_line(0, 1, 0, 0, "clean confirmed R2 R7");
        run_line(0, 0, 0, 0, "unlocked scan R3");
        run_line(0, 0, 1, 0, "unlocked retrace R3");
        run_line(1, 0, 1, 0, "unlocked noisy R3");
        run_line(1, 0, 0, 0, "unlocked noisy confirmed R3 R2");
        run_line(1, 1, 1, 1, "weak with mid-line toggles R9");
        run_line(0, 1, 1, 1, "mid-line toggles R9");
        run_line(0, 1, 1, 1, "strong retrace with toggles R9 R6");

        nz = 1'b0;
        vr = 1'b0;
        for (int l = 0; l < 110; l++) begin
            if ($urandom_range(0, 3) == 0) nz = ~nz;
            lk = ($urandom_range(0, 4) != 0);
            vr = ($urandom_range(0, 5) == 0) ? ~vr : vr;
            run_line(nz, lk, vr, 1, "random R9");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule